// File: doc/BRIEF.md
# Dual Interval Timer

This block provides two independent down-counting timers and one shared interrupt line, all reached through a small word-addressed register port. Each timer has three registers: a reload value, a control word and a read-only live count. A control write does two things. It picks which of four external tick-enable inputs clocks the timer, and it issues a command: load the reload value, hold, or run. A running timer counts down by one on every selected tick. When it reaches zero, it reloads itself and flags an expiry.

Expiries set bits in a shared status register. Software filters them through a mask register and clears them by writing ones to an acknowledge register. The interrupt output is high while any unmasked status bit is set. A separate readback returns the masked status. Registers are written in one cycle. Reads are combinational from the address.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both counts, the status register and the mask register read zero, and `irq` is low.
- R2: A control write with operation field bits [1:0] = 0 copies the timer's reload register into its count and leaves the timer stopped.
- R3: Operation code 1 (hold) and operation code 3 both stop the timer, so the count does not change on any tick.
- R4: Operation code 2 (run) makes the count drop by one on each cycle where the selected tick enable is high.
- R5: Control bits [4:2] select the tick source. Codes 4, 5, 6 and 7 select `tick_en[0]`, `[1]`, `[2]` and `[3]` respectively. Codes 0 to 3 select no tick, and ticks on unselected inputs are ignored.
- R6: A running timer whose count is zero reloads from its reload register on the next selected tick and raises an expiry in that same tick. The period is therefore reload+1 ticks.
- R7: An expiry of timer 0 sets status bit 0, and an expiry of timer 1 sets status bit 1.
- R8: Writing the acknowledge register (offset 0x4C) clears each status bit written as 1. A status bit set in the same cycle stays set. The acknowledge register reads zero.
- R9: The masked status (offset 0x54) reads raw status AND mask, and `irq` is high exactly when that value is nonzero, one cycle after a mask, acknowledge or expiry event.
- R10: Writing a reload register (timer 0 at 0x00, timer 1 at 0x10) does not change the live count; the new value is used only from the next load or reload.
- R11: The register map is as follows:
  - count registers at 0x04 and 0x14;
  - control registers at 0x08 and 0x18;
  - mask at 0x48;
  - raw status at 0x50.

  Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| tick_en | input | NUM_SRC | Tick enables for source codes 4 and up |
| irq | output | 1 | Interrupt, OR of masked status bits |

## Verification
The assertions check three things on every cycle. A stopped timer never changes its count. A running timer that takes a tick at a nonzero count drops by exactly one. The other assertions cover the status register: a status bit only rises on an expiry, an acknowledged bit clears unless it is set again in that cycle, and `irq` only rises after an expiry or a mask write. The bench scenarios cover what needs a particular register history to show:
- the exact reload period;
- the mapping from source codes to tick inputs;
- that a reload write leaves the live count alone until the next load;
- the masked readback;
- the zero reads at unmapped offsets.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSVD = 2'd3
  } dtt_op_e;

  localparam int NUM_TMR    = 2;
  localparam int CTRL_W     = 5;
  localparam int SRC_BASE   = 4;
  localparam int TMR_STRIDE = 'h10;
  localparam int OFF_DIV    = 'h00;
  localparam int OFF_CNT    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_MASK   = 'h48;
  localparam int OFF_ACK    = 'h4C;
  localparam int OFF_RAW    = 'h50;
  localparam int OFF_MSKD   = 'h54;
endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
  import dtt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_we,
  input  logic               ctrl_we,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] tick_vec,
  output logic [CNT_W-1:0]   div_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               expire_o
);
  logic [CNT_W-1:0]  div_q, div_d, cnt_q, cnt_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              run_q, run_d;
  logic              tick_sel;
  dtt_op_e           wop;

  assign wop = dtt_op_e'(wdata[1:0]);

  always_comb begin
    tick_sel = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (32'(ctrl_q[CTRL_W-1:2]) == 32'(SRC_BASE + s)) tick_sel = tick_vec[s];
    end
  end

  always_comb begin
    div_d    = div_we ? wdata : div_q;
    ctrl_d   = ctrl_q;
    cnt_d    = cnt_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (ctrl_we) begin
      ctrl_d = wdata[CTRL_W-1:0];
      case (wop)
        OP_LOAD: begin cnt_d = div_q; run_d = 1'b0; end
        OP_RUN:  run_d = 1'b1;
        default: run_d = 1'b0;
      endcase
    end else if (run_q && tick_sel) begin
      if (cnt_q == '0) begin
        cnt_d    = div_q;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
    end
  end

  assign div_o   = div_q;
  assign ctrl_o  = ctrl_q;
  assign count_o = cnt_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctrl_we) |=> $stable(count_o));
  // R4
  run_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_sel && !ctrl_we && cnt_q != '0) |=> (count_o == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] st_q, st_d, mk_q, mk_d;

  always_comb begin
    mk_d = mask_we ? wdata : mk_q;
    st_d = st_q;
    if (ack_we) st_d = st_d & ~wdata;
    st_d = st_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      st_q <= st_d;
      mk_q <= mk_d;
    end
  end

  assign mask_o   = mk_q;
  assign status_o = st_q;
  assign irq_o    = |(st_q & mk_q);

  // R7
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(st_q & ~$past(st_q)) != 0) |-> ($past(set_i) != '0));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ((wdata & ~set_i) != '0)) |=> ((st_q & $past(wdata & ~set_i)) == '0));
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(set_i) != '0 || $past(mask_we)));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tick_en,
  output logic               irq
);
  logic [DATA_W-1:0]  div_a  [NUM_TMR];
  logic [DATA_W-1:0]  cnt_a  [NUM_TMR];
  logic [CTRL_W-1:0]  ctrl_a [NUM_TMR];
  logic [NUM_TMR-1:0] expire;
  logic [NUM_TMR-1:0] mask, status;
  logic               mask_we, ack_we;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(g * TMR_STRIDE + OFF_DIV);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(g * TMR_STRIDE + OFF_CTRL);
    dtt_counter #(.CNT_W(DATA_W), .NUM_SRC(NUM_SRC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_we   (bus_we && bus_addr == A_DIV),
      .ctrl_we  (bus_we && bus_addr == A_CTRL),
      .wdata    (bus_wdata),
      .tick_vec (tick_en),
      .div_o    (div_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .count_o  (cnt_a[g]),
      .expire_o (expire[g])
    );
  end

  assign mask_we = bus_we && bus_addr == ADDR_W'(OFF_MASK);
  assign ack_we  = bus_we && bus_addr == ADDR_W'(OFF_ACK);

  dtt_irq #(.N(NUM_TMR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (expire),
    .mask_we  (mask_we),
    .ack_we   (ack_we),
    .wdata    (bus_wdata[NUM_TMR-1:0]),
    .mask_o   (mask),
    .status_o (status),
    .irq_o    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFF_DIV))  bus_rdata = div_a[i];
      if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFF_CNT))  bus_rdata = cnt_a[i];
      if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFF_CTRL)) bus_rdata = DATA_W'(ctrl_a[i]);
    end
    if (bus_addr == ADDR_W'(OFF_MASK)) bus_rdata = DATA_W'(mask);
    if (bus_addr == ADDR_W'(OFF_RAW))  bus_rdata = DATA_W'(status);
    if (bus_addr == ADDR_W'(OFF_MSKD)) bus_rdata = DATA_W'(status & mask);
  end

  // R6
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> (cnt_a[0] == div_a[0]));
endmodule

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dual_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic tick(input int idx);
    @(negedge clk); tick_en = 4'b1 << idx;
    @(negedge clk); tick_en = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(7'h04, v); chk(v, 0, "R1 t0 count");
    rd(7'h50, v); chk(v, 0, "R1 status");
    rd(7'h48, v); chk(v, 0, "R1 mask");
    chk(32'(irq), 0, "R1 irq");
  endtask

  task automatic t_load_run_expire;
    logic [31:0] v;
    wr(7'h00, 3); wr(7'h08, 32'h10);
    rd(7'h04, v); chk(v, 3, "R2 load");
    rd(7'h08, v); chk(v, 32'h10, "R11 ctrl readback");
    wr(7'h08, 32'h12);
    for (int k = 0; k < 3; k++) tick(0);
    rd(7'h04, v); chk(v, 0, "R4 three ticks");
    rd(7'h50, v); chk(v, 0, "R6 no early expiry");
    tick(0);
    rd(7'h04, v); chk(v, 3, "R6 reload");
    rd(7'h50, v); chk(v, 1, "R7 status bit0");
    chk(32'(irq), 0, "R9 masked off");
  endtask

  task automatic t_mask_ack;
    logic [31:0] v;
    wr(7'h48, 1);
    chk(32'(irq), 1, "R9 irq after mask");
    rd(7'h54, v); chk(v, 1, "R9 masked status");
    wr(7'h4C, 1);
    chk(32'(irq), 0, "R8 irq after ack");
    rd(7'h50, v); chk(v, 0, "R8 status cleared");
    rd(7'h4C, v); chk(v, 0, "R8 ack reads zero");
  endtask

  task automatic t_hold_and_sources;
    logic [31:0] v;
    wr(7'h08, 32'h11); tick(0);
    rd(7'h04, v); chk(v, 3, "R3 hold");
    wr(7'h08, 32'h13); tick(0);
    rd(7'h04, v); chk(v, 3, "R3 op3 holds");
    wr(7'h08, 32'h16); tick(0); tick(2); tick(3);
    rd(7'h04, v); chk(v, 3, "R5 unselected ignored");
    tick(1);
    rd(7'h04, v); chk(v, 2, "R5 code5 uses tick1");
    wr(7'h08, 32'h06);
    for (int k = 0; k < 4; k++) tick(k);
    rd(7'h04, v); chk(v, 2, "R5 code1 no tick");
  endtask

  task automatic t_divider_write;
    logic [31:0] v;
    wr(7'h00, 7);
    rd(7'h04, v); chk(v, 2, "R10 count unchanged");
    wr(7'h08, 32'h10);
    rd(7'h04, v); chk(v, 7, "R10 new value on load");
  endtask

  task automatic t_timer1;
    logic [31:0] v;
    wr(7'h10, 0); wr(7'h18, 32'h1C); wr(7'h18, 32'h1E);
    tick(3);
    rd(7'h50, v); chk(v, 2, "R7 status bit1");
    rd(7'h14, v); chk(v, 0, "R11 t1 count");
    rd(7'h38, v); chk(v, 0, "R11 unmapped");
    wr(7'h48, 3);
    chk(32'(irq), 1, "R9 irq timer1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_load_run_expire;
    t_mask_ack;
    t_hold_and_sources;
    t_divider_write;
    t_timer1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule